// File: doc/BRIEF.md
# Queued SPI Master with Slot Command Memory

This block is an SPI master that works through a small queue of byte transfers. A host fills up to sixteen slots through a simple register port. Each slot has an outgoing byte, a byte captured from the far side, and a short command word. The command word picks the chip-select lines for the slot and says whether chip select stays asserted into the following slot. The host then writes the first and last slot of the run and sets the enable bit. The block shifts the slots in turn and stores each received byte in its slot. When the run ends it drops the enable bit and raises a sticky completion flag.

A flash command longer than the queue can span several runs. If the hold-after-run control bit and the lock register are both set, chip select is not released when a run ends. The host reloads the slots and starts another run, which continues the same transaction. Clearing the lock lets chip select go. The serial clock has polarity 1 and phase 1. A configurable idle gap in system clocks can be inserted between bytes.

Top module: `spi_queue_master`

## Requirements
- R1: After reset, sck is 1, every cs_n line is 1, and register 0x00 bit 0 (enable/busy) and register 0x01 bit 0 (done) both read 0.
- R2: A run transfers slots from the start pointer (register 0x02) through the end pointer (register 0x03) inclusive, one byte per slot. Each byte goes out MSB first from the slot's TX byte (0x10+i). mosi changes only on falling sck edges, and miso is sampled on rising edges. The received byte is readable at 0x20+i.
- R3: Writing 1 to bit 0 of register 0x00 while idle starts a run. Bit 0 reads 1 while the run is active. Hardware clears it at the end of the run and sets done (0x01 bit 0).
- R4: Done stays at 1 until the host writes 0x01 with bit 0 cleared. Writing it with bit 0 set leaves it at 1.
- R5: In a slot command word (0x30+i), bit 0 is the continue flag. A slot with continue set keeps chip select asserted into the next slot of the run. A slot with continue cleared releases chip select after its byte.
- R6: When hold-after-run (0x00 bit 1) and lock (0x06 bit 0) are both 1, chip select stays asserted after the run ends and through a following run. Clearing lock while idle releases chip select.
- R7: sck idles at 1. Each half period lasts BAUD system clocks (register 0x04), so the period is 2*BAUD clocks. A BAUD value of 0 acts as 1.
- R8: Register 0x05 (GAP) adds exactly GAP system clocks between consecutive bytes of a run. Values up to 255, including 128, are supported.
- R9: While a run is active, writes to the pointers, the slot TX and command bytes, the control bits, BAUD and GAP are ignored.
- R10: Command bits [NCS:1] select chip-select lines. cs_n[k] is driven low during a slot whose command bit k+1 is 1.
- R11: If the start pointer is greater than the end pointer, the run wraps from the last slot to slot 0 and stops after the end slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address: [5:4] region (control, TX, RX, command), [3:0] offset or slot |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
The bench sends complementary and asymmetric byte patterns (A5/3C/F0 out against 5A/C3/0F back), so bit-order or sampling-edge errors corrupt both directions. Command patterns compare a run with all slots continued against one with a break in the middle, and a hold-and-lock run against a normal one. Counting chip-select releases separates per-slot release, end-of-run release and held release. Pointer patterns include a normal ascending run and a wrapped run from slot 14 to slot 1. Timing patterns compare BAUD 3 against BAUD 0, and GAP 128 against GAP 0, so an off-by-one in either counter shows as a difference in clock count.

// File: rtl/spiq_pkg.sv
`timescale 1ns/1ps
package spiq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LOAD  = 3'd1,
      ST_SHIFT = 3'd2,
      ST_FIN   = 3'd3,
      ST_GAP   = 3'd4
   } eng_state_t;

   localparam logic [1:0] RGN_CTL = 2'd0;
   localparam logic [1:0] RGN_TX  = 2'd1;
   localparam logic [1:0] RGN_RX  = 2'd2;
   localparam logic [1:0] RGN_CMD = 2'd3;

   localparam logic [3:0] OFS_CTRL = 4'h0;
   localparam logic [3:0] OFS_STAT = 4'h1;
   localparam logic [3:0] OFS_SPTR = 4'h2;
   localparam logic [3:0] OFS_EPTR = 4'h3;
   localparam logic [3:0] OFS_BAUD = 4'h4;
   localparam logic [3:0] OFS_GAP  = 4'h5;
   localparam logic [3:0] OFS_LOCK = 4'h6;
endpackage

// File: rtl/spiq_baud.sv
`timescale 1ns/1ps
module spiq_baud #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] baud,
   output logic             tick
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   assign lim  = (baud == '0) ? CNT_W'(1) : baud;
   assign tick = run && (cnt == lim - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   p_cnt_below_lim_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < lim));
endmodule

// File: rtl/spiq_regs.sv
`timescale 1ns/1ps
module spiq_regs
   import spiq_pkg::*;
#(
   parameter int SLOTS  = 16,
   parameter int PTR_W  = 4,
   parameter int DATA_W = 8,
   parameter int CMD_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [5:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              busy,
   input  logic              rx_we,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              done_set,
   input  logic [PTR_W-1:0]  cur_ptr,
   output logic [DATA_W-1:0] cur_tx,
   output logic [CMD_W-1:0]  cur_cmd,
   output logic              start,
   output logic [PTR_W-1:0]  start_ptr,
   output logic [PTR_W-1:0]  end_ptr,
   output logic [DATA_W-1:0] baud,
   output logic [DATA_W-1:0] gap,
   output logic              hold,
   output logic              lock
);
   logic [1:0]       rgn;
   logic [3:0]       ofs;
   logic [PTR_W-1:0] idx;
   logic             ctl_wr;
   logic             done_q;
   logic [SLOTS-1:0] tx_we;
   logic [SLOTS-1:0] cmd_we;

   logic [DATA_W-1:0] tx_q  [SLOTS];
   logic [DATA_W-1:0] rx_q  [SLOTS];
   logic [CMD_W-1:0]  cmd_q [SLOTS];

   assign rgn    = reg_addr[5:4];
   assign ofs    = reg_addr[3:0];
   assign idx    = reg_addr[PTR_W-1:0];
   assign ctl_wr = reg_wr && (rgn == RGN_CTL);
   assign start  = ctl_wr && (ofs == OFS_CTRL) && reg_wdata[0] && !busy;

   // per-slot write enables, all blocked while a run is active
   for (genvar i = 0; i < SLOTS; i++) begin : g_slot_we
      assign tx_we[i]  = reg_wr && !busy && (rgn == RGN_TX)  && (idx == PTR_W'(i));
      assign cmd_we[i] = reg_wr && !busy && (rgn == RGN_CMD) && (idx == PTR_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold      <= 1'b0;
         start_ptr <= '0;
         end_ptr   <= '0;
         baud      <= DATA_W'(1);
         gap       <= '0;
      end else if (ctl_wr && !busy) begin
         case (ofs)
            OFS_CTRL: hold      <= reg_wdata[1];
            OFS_SPTR: start_ptr <= reg_wdata[PTR_W-1:0];
            OFS_EPTR: end_ptr   <= reg_wdata[PTR_W-1:0];
            OFS_BAUD: baud      <= reg_wdata;
            OFS_GAP:  gap       <= reg_wdata;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock <= 1'b0;
      end else if (ctl_wr && (ofs == OFS_LOCK)) begin
         lock <= reg_wdata[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else if (done_set) begin
         done_q <= 1'b1;
      end else if (ctl_wr && (ofs == OFS_STAT) && !reg_wdata[0]) begin
         done_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) begin
            tx_q[i]  <= '0;
            rx_q[i]  <= '0;
            cmd_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < SLOTS; i++) begin
            if (tx_we[i])  tx_q[i]  <= reg_wdata;
            if (cmd_we[i]) cmd_q[i] <= reg_wdata[CMD_W-1:0];
            if (rx_we && (cur_ptr == PTR_W'(i))) rx_q[i] <= rx_data;
         end
      end
   end

   assign cur_tx  = tx_q[cur_ptr];
   assign cur_cmd = cmd_q[cur_ptr];

   always_comb begin
      reg_rdata = '0;
      case (rgn)
         RGN_CTL: begin
            case (ofs)
               OFS_CTRL: reg_rdata[1:0]       = {hold, busy};
               OFS_STAT: reg_rdata[0]         = done_q;
               OFS_SPTR: reg_rdata[PTR_W-1:0] = start_ptr;
               OFS_EPTR: reg_rdata[PTR_W-1:0] = end_ptr;
               OFS_BAUD: reg_rdata            = baud;
               OFS_GAP:  reg_rdata            = gap;
               OFS_LOCK: reg_rdata[0]         = lock;
               default:  reg_rdata            = '0;
            endcase
         end
         RGN_TX:  reg_rdata              = tx_q[idx];
         RGN_RX:  reg_rdata              = rx_q[idx];
         default: reg_rdata[CMD_W-1:0]   = cmd_q[idx];
      endcase
   end

   p_ptr_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(start_ptr) && $stable(end_ptr) && $stable(gap) && $stable(baud)));

   p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !(ctl_wr && (ofs == OFS_STAT) && !reg_wdata[0])) |=> done_q);

   p_done_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_set |=> done_q);
endmodule

// File: rtl/spiq_engine.sv
`timescale 1ns/1ps
module spiq_engine
   import spiq_pkg::*;
#(
   parameter int PTR_W  = 4,
   parameter int DATA_W = 8,
   parameter int NCS    = 2,
   parameter int CMD_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PTR_W-1:0]  start_ptr,
   input  logic [PTR_W-1:0]  end_ptr,
   input  logic [DATA_W-1:0] gap,
   input  logic              hold,
   input  logic              lock,
   input  logic [DATA_W-1:0] cur_tx,
   input  logic [CMD_W-1:0]  cur_cmd,
   input  logic              tick,
   input  logic              miso,
   output logic [PTR_W-1:0]  cur_ptr,
   output logic              busy,
   output logic              clk_run,
   output logic              sck,
   output logic              mosi,
   output logic [NCS-1:0]    cs_n,
   output logic              rx_we,
   output logic [DATA_W-1:0] rx_data,
   output logic              done_set
);
   localparam int BIT_W = $clog2(DATA_W);

   eng_state_t        state;
   logic [PTR_W-1:0]  ptr;
   logic [BIT_W-1:0]  bitc;
   logic [DATA_W-1:0] sh_tx;
   logic [DATA_W-1:0] sh_rx;
   logic [DATA_W-1:0] gcnt;
   logic              last;
   logic              cont;
   logic              keep;
   logic [NCS-1:0]    sel;

   assign last = (ptr == end_ptr);
   assign cont = cur_cmd[0];
   assign sel  = cur_cmd[NCS:1];
   assign keep = hold && lock;

   assign cur_ptr  = ptr;
   assign busy     = (state != ST_IDLE);
   assign clk_run  = (state == ST_SHIFT);
   assign rx_we    = (state == ST_FIN);
   assign rx_data  = sh_rx;
   assign done_set = (state == ST_FIN) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         ptr   <= '0;
         bitc  <= '0;
         sh_tx <= '0;
         sh_rx <= '0;
         gcnt  <= '0;
         sck   <= 1'b1;
         mosi  <= 1'b0;
         cs_n  <= '1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (!keep) cs_n <= '1;
               if (start) begin
                  ptr   <= start_ptr;
                  state <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               cs_n  <= ~sel;
               sh_tx <= cur_tx;
               bitc  <= '0;
               state <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (sck) begin
                     sck   <= 1'b0;
                     mosi  <= sh_tx[DATA_W-1];
                     sh_tx <= {sh_tx[DATA_W-2:0], 1'b0};
                  end else begin
                     sck   <= 1'b1;
                     sh_rx <= {sh_rx[DATA_W-2:0], miso};
                     if (bitc == BIT_W'(DATA_W - 1)) begin
                        bitc  <= '0;
                        state <= ST_FIN;
                     end else begin
                        bitc <= bitc + 1'b1;
                     end
                  end
               end
            end
            ST_FIN: begin
               if (last) begin
                  if (!keep) cs_n <= '1;
                  state <= ST_IDLE;
               end else begin
                  if (!cont) cs_n <= '1;
                  ptr <= ptr + 1'b1;
                  if (gap != '0) begin
                     gcnt  <= gap - 1'b1;
                     state <= ST_GAP;
                  end else begin
                     state <= ST_LOAD;
                  end
               end
            end
            ST_GAP: begin
               if (gcnt == '0) state <= ST_LOAD;
               else            gcnt  <= gcnt - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_sck_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck);

   p_mosi_steady_at_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(mosi));

   p_cs_steady_in_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT) |=> $stable(cs_n));

   p_run_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_set |=> !busy);
endmodule

// File: rtl/spi_queue_master.sv
`timescale 1ns/1ps
module spi_queue_master #(
   parameter int SLOTS  = 16,
   parameter int DATA_W = 8,
   parameter int NCS    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [5:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic [NCS-1:0]    cs_n
);
   localparam int PTR_W = $clog2(SLOTS);
   localparam int CMD_W = NCS + 1;

   if (SLOTS < 2 || SLOTS > 16 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two between 2 and 16");
   end
   if (CMD_W > DATA_W || DATA_W < 2) begin : g_bad_width
      $error("command word must fit in a register byte");
   end

   logic              busy;
   logic              start;
   logic              tick;
   logic              clk_run;
   logic              rx_we;
   logic              done_set;
   logic              hold;
   logic              lock;
   logic [PTR_W-1:0]  cur_ptr;
   logic [PTR_W-1:0]  start_ptr;
   logic [PTR_W-1:0]  end_ptr;
   logic [DATA_W-1:0] cur_tx;
   logic [DATA_W-1:0] rx_data;
   logic [DATA_W-1:0] baud;
   logic [DATA_W-1:0] gap;
   logic [CMD_W-1:0]  cur_cmd;

   spiq_regs #(
      .SLOTS(SLOTS), .PTR_W(PTR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .busy(busy), .rx_we(rx_we), .rx_data(rx_data), .done_set(done_set),
      .cur_ptr(cur_ptr), .cur_tx(cur_tx), .cur_cmd(cur_cmd),
      .start(start), .start_ptr(start_ptr), .end_ptr(end_ptr),
      .baud(baud), .gap(gap), .hold(hold), .lock(lock)
   );

   spiq_baud #(.CNT_W(DATA_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(clk_run), .baud(baud), .tick(tick)
   );

   spiq_engine #(
      .PTR_W(PTR_W), .DATA_W(DATA_W), .NCS(NCS), .CMD_W(CMD_W)
   ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .start(start), .start_ptr(start_ptr), .end_ptr(end_ptr),
      .gap(gap), .hold(hold), .lock(lock),
      .cur_tx(cur_tx), .cur_cmd(cur_cmd), .tick(tick), .miso(miso),
      .cur_ptr(cur_ptr), .busy(busy), .clk_run(clk_run),
      .sck(sck), .mosi(mosi), .cs_n(cs_n),
      .rx_we(rx_we), .rx_data(rx_data), .done_set(done_set)
   );
endmodule

// File: tb/tb_spi_queue_master.sv
`timescale 1ns/1ps
module tb_spi_queue_master;
   localparam int NCS = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_wr = 1'b0;
   logic [5:0]     reg_addr = '0;
   logic [7:0]     reg_wdata = '0;
   logic [7:0]     reg_rdata;
   logic           sck;
   logic           mosi;
   logic           miso = 1'b0;
   logic [NCS-1:0] cs_n;

   int n_chk = 0;
   int n_bad = 0;
   bit armed = 1'b0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   spi_queue_master #(.SLOTS(16), .DATA_W(8), .NCS(NCS)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   // far-side device model
   logic [7:0]     resp  [64];
   logic [7:0]     got   [64];
   logic [NCS-1:0] cs_at [64];
   int   sl_cnt = 0;
   int   bitc = 0;
   logic [7:0] sh = '0;
   time  t_rise = 0;
   time  t_prev_rise = 0;
   time  gap_meas = 0;
   int   rel0 = 0;

   always @(negedge sck) begin
      if (armed) begin
         miso = resp[sl_cnt % 64][7 - bitc];
         if (bitc == 0) gap_meas = $time - t_rise;
      end
   end

   always @(posedge sck) begin
      if (armed) begin
         if (bitc == 0) cs_at[sl_cnt % 64] = cs_n;
         sh = {sh[6:0], mosi};
         bitc = bitc + 1;
         if (bitc == 8) begin
            got[sl_cnt % 64] = sh;
            sl_cnt = sl_cnt + 1;
            bitc = 0;
         end
         t_prev_rise = t_rise;
         t_rise = $time;
      end
   end

   always @(posedge cs_n[0]) if (armed) rel0 = rel0 + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] v;
      bit ok = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         rd(6'h00, v);
         if (v[0] == 1'b0) begin ok = 1'b1; break; end
      end
      if (!ok) chk("R3 run never ended", 32'd0, 32'd1);
   endtask

   task automatic start_run(input logic [3:0] sp, input logic [3:0] ep, input bit hold);
      wr(6'h02, {4'h0, sp});
      wr(6'h03, {4'h0, ep});
      wr(6'h00, {6'd0, hold, 1'b1});
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 sck idle", {31'd0, sck}, 32'd1);
      chk("R1 cs_n idle", {30'd0, cs_n}, 32'd3);
      rd(6'h00, v); chk("R1 enable bit", {31'd0, v[0]}, 32'd0);
      rd(6'h01, v); chk("R1 done flag", {31'd0, v[0]}, 32'd0);
   endtask

   task automatic t_basic();
      logic [7:0] v;
      logic [7:0] tx [3];
      logic [7:0] rs [3];
      int b, r;
      tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'hF0;
      rs[0] = 8'h5A; rs[1] = 8'hC3; rs[2] = 8'h0F;
      b = sl_cnt; r = rel0;
      wr(6'h04, 8'd2); wr(6'h05, 8'd0);
      for (int k = 0; k < 3; k++) begin
         wr(6'h10 + 6'(k), tx[k]);
         wr(6'h30 + 6'(k), (k == 2) ? 8'b010 : 8'b011);
         resp[(b + k) % 64] = rs[k];
      end
      start_run(4'd0, 4'd2, 1'b0);
      rd(6'h00, v); chk("R3 busy during run", {31'd0, v[0]}, 32'd1);
      wait_idle();
      rd(6'h01, v); chk("R3 done after run", {31'd0, v[0]}, 32'd1);
      chk("R2 byte count", sl_cnt - b, 32'd3);
      for (int k = 0; k < 3; k++) begin
         chk("R2 mosi byte", {24'd0, got[(b + k) % 64]}, {24'd0, tx[k]});
         rd(6'h20 + 6'(k), v);
         chk("R2 rx slot", {24'd0, v}, {24'd0, rs[k]});
         chk("R10 cs0 selected", {30'd0, cs_at[(b + k) % 64]}, 32'd2);
      end
      chk("R5 one release with all continued", rel0 - r, 32'd1);
      chk("R7 sck high after run", {31'd0, sck}, 32'd1);
   endtask

   task automatic t_done_sticky();
      logic [7:0] v;
      wr(6'h01, 8'h01);
      rd(6'h01, v); chk("R4 done kept on write of 1", {31'd0, v[0]}, 32'd1);
      wr(6'h01, 8'h00);
      rd(6'h01, v); chk("R4 done cleared on write of 0", {31'd0, v[0]}, 32'd0);
   endtask

   task automatic t_cont_break();
      int r;
      r = rel0;
      wr(6'h30, 8'b011); wr(6'h31, 8'b010); wr(6'h32, 8'b010);
      start_run(4'd0, 4'd2, 1'b0);
      wait_idle();
      chk("R5 release after non-continued slot", rel0 - r, 32'd2);
   endtask

   task automatic t_cs_select();
      int b;
      b = sl_cnt;
      wr(6'h35, 8'b100);
      wr(6'h15, 8'h81);
      start_run(4'd5, 4'd5, 1'b0);
      wait_idle();
      chk("R10 cs1 selected", {30'd0, cs_at[b % 64]}, 32'd1);
      chk("R10 cs released after run", {30'd0, cs_n}, 32'd3);
   endtask

   task automatic t_baud();
      wr(6'h04, 8'd3);
      start_run(4'd0, 4'd0, 1'b0);
      wait_idle();
      chk("R7 period with BAUD 3", 32'((t_rise - t_prev_rise) / 20), 32'd6);
      wr(6'h04, 8'd0);
      start_run(4'd0, 4'd0, 1'b0);
      wait_idle();
      chk("R7 period with BAUD 0", 32'((t_rise - t_prev_rise) / 20), 32'd2);
      wr(6'h04, 8'd2);
   endtask

   task automatic t_gap();
      time g0, g1;
      wr(6'h30, 8'b011); wr(6'h31, 8'b010);
      wr(6'h05, 8'd0);
      start_run(4'd0, 4'd1, 1'b0);
      wait_idle();
      g0 = gap_meas;
      wr(6'h05, 8'd128);
      start_run(4'd0, 4'd1, 1'b0);
      wait_idle();
      g1 = gap_meas;
      chk("R8 gap of 128 clocks", 32'((g1 - g0) / 20), 32'd128);
      wr(6'h05, 8'd0);
   endtask

   task automatic t_hold();
      int b, r;
      b = sl_cnt; r = rel0;
      wr(6'h30, 8'b011); wr(6'h31, 8'b011);
      wr(6'h06, 8'h01);
      start_run(4'd0, 4'd1, 1'b1);
      wait_idle();
      chk("R6 cs held after first run", {31'd0, cs_n[0]}, 32'd0);
      wr(6'h10, 8'h11); wr(6'h11, 8'h22);
      start_run(4'd0, 4'd1, 1'b1);
      wait_idle();
      chk("R6 cs held after second run", {31'd0, cs_n[0]}, 32'd0);
      chk("R6 no release across runs", rel0 - r, 32'd0);
      chk("R6 bytes in joined transaction", sl_cnt - b, 32'd4);
      wr(6'h06, 8'h00);
      repeat (3) @(negedge clk);
      chk("R6 release after lock cleared", {31'd0, cs_n[0]}, 32'd1);
      chk("R6 single release", rel0 - r, 32'd1);
      wr(6'h00, 8'h00);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] v;
      int b;
      b = sl_cnt;
      wr(6'h04, 8'd8);
      for (int k = 0; k < 4; k++) begin
         wr(6'h10 + 6'(k), 8'h40 + 8'(k));
         wr(6'h30 + 6'(k), 8'b011);
      end
      start_run(4'd0, 4'd3, 1'b0);
      rd(6'h00, v); chk("R9 busy seen", {31'd0, v[0]}, 32'd1);
      wr(6'h02, 8'h09);
      wr(6'h13, 8'h77);
      wait_idle();
      rd(6'h02, v); chk("R9 start pointer unchanged", {24'd0, v}, 32'd0);
      rd(6'h13, v); chk("R9 tx slot unchanged", {24'd0, v}, 32'h43);
      chk("R9 sent byte unchanged", {24'd0, got[(b + 3) % 64]}, 32'h43);
      wr(6'h04, 8'd2);
   endtask

   task automatic t_wrap();
      logic [7:0] v;
      int b;
      b = sl_cnt;
      wr(6'h1E, 8'hE1); wr(6'h1F, 8'hF2); wr(6'h10, 8'h03); wr(6'h11, 8'h14);
      wr(6'h3E, 8'b011); wr(6'h3F, 8'b011); wr(6'h30, 8'b011); wr(6'h31, 8'b010);
      for (int k = 0; k < 4; k++) resp[(b + k) % 64] = 8'hB0 + 8'(k);
      start_run(4'd14, 4'd1, 1'b0);
      wait_idle();
      chk("R11 wrapped byte count", sl_cnt - b, 32'd4);
      chk("R11 order slot15", {24'd0, got[(b + 1) % 64]}, 32'hF2);
      chk("R11 order slot0", {24'd0, got[(b + 2) % 64]}, 32'h03);
      rd(6'h2F, v); chk("R11 rx slot15", {24'd0, v}, 32'hB1);
      rd(6'h20, v); chk("R11 rx slot0", {24'd0, v}, 32'hB2);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R3 actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) resp[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      armed = 1'b1;
      t_reset();
      t_basic();
      t_done_sticky();
      t_cont_break();
      t_cs_select();
      t_baud();
      t_gap();
      t_hold();
      t_busy_ignore();
      t_wrap();
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule